// File: doc/BRIEF.md
# Load/Store Execution Unit

This unit carries out the 32-bit base-integer load and store instructions against a single word-wide data memory port. It accepts one decoded-at-the-edge instruction word together with the two source register values. It adds the sign-extended immediate to the base register to form the effective address. It then issues one request with a word-aligned address, per-byte write enables and lane-steered store data, and holds that request until the memory accepts it.

Load data comes back as a full word. The unit picks out the byte or halfword selected by the low address bits and widens it to 32 bits, with sign extension or zero extension. It then presents a register write request for the destination register. Sub-word accesses that cross their natural alignment are refused: the unit raises a one-cycle flag and issues no memory request. Instruction words that are not a supported load or store are taken and dropped without any effect.

Top module: `ldst_unit`

## Requirements
- R1: The effective address is `rs1_val` plus the 12-bit immediate, sign-extended. For loads (opcode 0000011) the immediate is `instr[31:20]`. For stores (opcode 0100011) the immediate is `{instr[31:25], instr[11:7]}`. `mem_addr` carries this address with bits 1:0 cleared.
- R2: Load width and extension follow funct3 (`instr[14:12]`). 000 is a byte, sign-extended. 001 is a halfword, sign-extended. 010 is a full word. 100 is a byte, zero-extended. 101 is a halfword, zero-extended.
- R3: A loaded byte is taken from lane `addr[1:0]` of `mem_rdata`. A loaded halfword is taken from bits 15:0 when `addr[1]` is 0, and from bits 31:16 when `addr[1]` is 1.
- R4: Stores drive `mem_we`=1. funct3 000 stores the low 8 bits of `rs2_val`, 001 the low 16 bits and 010 all 32 bits. Each enabled lane of `mem_wdata` holds the matching byte of that value.
- R5: `mem_be` marks exactly the lanes of the access. A byte access sets bit `addr[1:0]`. A halfword access sets 0011 when `addr[1]`=0 and 1100 when `addr[1]`=1. A word access sets 1111. Loads drive `mem_we`=0.
- R6: A load whose destination field (`instr[11:7]`) is 0 still performs the memory read and still pulses `done`, but `wb_valid` stays 0.
- R7: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, raises `misalign` for one cycle. That cycle is the one after acceptance. No memory request follows.
- R8: While `mem_valid` is high and `mem_ready` is low, the request stays asserted with address, enables and data unchanged. `req_ready` stays low from acceptance until completion.
- R9: `done` is high for exactly one cycle. For a store, that is the cycle after the request handshake. For a load, it is the cycle after `mem_rvalid`, together with `wb_valid`, `wb_rd` and `wb_data`.
- R10: An instruction with any other opcode, or a load/store funct3 outside the lists above, is accepted but causes no memory request, no `done` and no `misalign`.
- R11: After reset, `req_ready`=1 and `mem_valid`, `done`, `wb_valid` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle, instruction taken when valid |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Base register value |
| rs2_val | input | 32 | Store source register value |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned request address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | Access completed (one cycle) |
| wb_valid | output | 1 | Register write request |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 32 | Extended load result |
| misalign | output | 1 | Misaligned access refused (one cycle) |

## Verification
A lane or offset latched wrongly shows up as a wrong `mem_be` at the handshake of the very request involved. It also shows as a wrong extended value on `wb_data` in the `done` cycle, one cycle after read data returns. A sequencer that drops or repeats a state shows as a handshake count other than one per access, as a `done` that lasts two cycles or never arrives, or as a request that stays up for more or fewer cycles than the memory stalls. The tests therefore cover every funct3 at every legal offset, stalled and unstalled memory, and destination zero.

// File: rtl/ldst_pkg.sv
// Shared encodings and decoded-instruction record for the load/store unit.
// Assumes the 32-bit base-integer instruction layout.
package ldst_pkg;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_t;

    typedef struct packed {
        logic       legal;
        logic       is_store;
        logic       sext;
        acc_size_t  size;
        logic [4:0] rd;
        logic [11:0] imm;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } fsm_t;

endpackage

// File: rtl/ldst_decode.sv
// Decodes a load or store instruction, forms the effective address and
// detects misalignment. Purely combinational; assumes DATA_W is a power
// of two of at least 32 bits.
module ldst_decode
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rs1_val,
    output dec_t              dec,
    output logic [DATA_W-1:0] ea,
    output logic              misal
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [OFF_W-1:0] off;
    logic        unused_fields;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign unused_fields = ^instr[24:15];

    // Field and width decode for the supported funct3 encodings.
    always_comb begin
        dec          = '0;
        dec.rd       = instr[11:7];
        dec.size     = SZ_BYTE;
        if (opc == OPC_LOAD) begin
            dec.imm = instr[31:20];
            dec.is_store = 1'b0;
            unique case (f3)
                3'b000: begin dec.legal = 1'b1; dec.size = SZ_BYTE; dec.sext = 1'b1; end
                3'b001: begin dec.legal = 1'b1; dec.size = SZ_HALF; dec.sext = 1'b1; end
                3'b010: begin dec.legal = 1'b1; dec.size = SZ_WORD; dec.sext = 1'b0; end
                3'b100: begin dec.legal = 1'b1; dec.size = SZ_BYTE; dec.sext = 1'b0; end
                3'b101: begin dec.legal = 1'b1; dec.size = SZ_HALF; dec.sext = 1'b0; end
                default: dec.legal = 1'b0;
            endcase
        end else if (opc == OPC_STORE) begin
            dec.imm      = {instr[31:25], instr[11:7]};
            dec.is_store = 1'b1;
            unique case (f3)
                3'b000:  begin dec.legal = 1'b1; dec.size = SZ_BYTE; end
                3'b001:  begin dec.legal = 1'b1; dec.size = SZ_HALF; end
                3'b010:  begin dec.legal = 1'b1; dec.size = SZ_WORD; end
                default: dec.legal = 1'b0;
            endcase
        end
    end

    // Effective address: base plus sign-extended immediate.
    assign ea  = rs1_val + {{(DATA_W-12){dec.imm[11]}}, dec.imm};
    assign off = ea[OFF_W-1:0];

    // Natural-alignment check for halfword and word accesses.
    always_comb begin
        unique case (dec.size)
            SZ_HALF: misal = off[0];
            SZ_WORD: misal = (off != '0);
            default: misal = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldst_store_lane.sv
// Builds byte enables and lane-steered write data for an access of the
// given size at the given in-word offset. Assumes the offset is aligned.
module ldst_store_lane
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_t                    size,
    input  logic [$clog2(DATA_W/8)-1:0]  off,
    input  logic [DATA_W-1:0]            src,
    output logic [DATA_W/8-1:0]          be,
    output logic [DATA_W-1:0]            wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(i);
        // Enable for this lane and the source byte that feeds it.
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    be[i]          = (off == LANE_IDX);
                    wdata[8*i +: 8] = src[7:0];
                end
                SZ_HALF: begin
                    be[i]          = (off[OFF_W-1:1] == LANE_IDX[OFF_W-1:1]);
                    wdata[8*i +: 8] = src[8*(i % 2) +: 8];
                end
                default: begin
                    be[i]          = (size == SZ_WORD);
                    wdata[8*i +: 8] = src[8*i +: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/ldst_load_extend.sv
// Selects the addressed byte or halfword from a returned data word and
// widens it with sign or zero fill. Assumes the offset is aligned.
module ldst_load_extend
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_t                    size,
    input  logic                         sext,
    input  logic [$clog2(DATA_W/8)-1:0]  off,
    input  logic [DATA_W-1:0]            rdata,
    output logic [DATA_W-1:0]            result
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic [7:0]  byte_v;
    logic [15:0] half_v;
    logic [OFF_W-2:0] half_idx;

    assign half_idx = off[OFF_W-1:1];
    assign byte_v   = rdata[8 * int'(off) +: 8];
    assign half_v   = rdata[16 * int'(half_idx) +: 16];

    // Width selection and fill.
    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sext & byte_v[7]}}, byte_v};
            SZ_HALF: result = {{(DATA_W-16){sext & half_v[15]}}, half_v};
            default: result = rdata;
        endcase
    end

endmodule

// File: rtl/ldst_unit.sv
// Load/store execution unit: accepts one instruction at a time, issues a
// single word-wide memory request, and returns load results as a register
// write. Assumes the memory returns read data some cycles after accepting
// a read and never for a write.
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] rs1_val,
    input  logic [DATA_W-1:0] rs2_val,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              wb_valid,
    output logic [4:0]        wb_rd,
    output logic [DATA_W-1:0] wb_data,
    output logic              misalign
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    fsm_t              st;
    dec_t              dec;
    logic [DATA_W-1:0] ea;
    logic              misal;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wdata_c;
    logic [DATA_W-1:0] ext_c;
    logic              fire;

    logic [DATA_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic [4:0]        rd_q;
    acc_size_t         size_q;
    logic              sext_q;
    logic              done_q;
    logic              wbv_q;
    logic [DATA_W-1:0] wbd_q;
    logic              mis_q;

    ldst_decode #(.DATA_W(DATA_W)) u_dec (
        .instr   (instr),
        .rs1_val (rs1_val),
        .dec     (dec),
        .ea      (ea),
        .misal   (misal)
    );

    ldst_store_lane #(.DATA_W(DATA_W)) u_lane (
        .size  (dec.size),
        .off   (ea[OFF_W-1:0]),
        .src   (rs2_val),
        .be    (be_c),
        .wdata (wdata_c)
    );

    ldst_load_extend #(.DATA_W(DATA_W)) u_ext (
        .size   (size_q),
        .sext   (sext_q),
        .off    (addr_q[OFF_W-1:0]),
        .rdata  (mem_rdata),
        .result (ext_c)
    );

    assign req_ready = (st == ST_IDLE);
    assign fire      = req_valid && req_ready;

    // Sequencer: accept, request, await read data, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            rd_q    <= '0;
            size_q  <= SZ_BYTE;
            sext_q  <= 1'b0;
            done_q  <= 1'b0;
            wbv_q   <= 1'b0;
            wbd_q   <= '0;
            mis_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            wbv_q  <= 1'b0;
            mis_q  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (fire && dec.legal) begin
                        if (misal) begin
                            mis_q <= 1'b1;
                        end else begin
                            addr_q  <= ea;
                            be_q    <= be_c;
                            wdata_q <= dec.is_store ? wdata_c : '0;
                            we_q    <= dec.is_store;
                            rd_q    <= dec.rd;
                            size_q  <= dec.size;
                            sext_q  <= dec.sext;
                            st      <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_ready) begin
                        if (we_q) begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        done_q <= 1'b1;
                        wbv_q  <= (rd_q != 5'd0);
                        wbd_q  <= ext_c;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port drive from registered state.
    assign mem_valid = (st == ST_REQ);
    assign mem_we    = we_q;
    assign mem_addr  = {addr_q[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_be    = be_q;
    assign mem_wdata = wdata_q;
    assign done      = done_q;
    assign wb_valid  = wbv_q;
    assign wb_rd     = rd_q;
    assign wb_data   = wbd_q;
    assign misalign  = mis_q;

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata) && $stable(mem_we))); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_MISALIGN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_valid && !done)); // R7
    AST_STORE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (mem_be != '0)); // R4
    AST_WB_NEVER_X0: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_rd != 5'd0 && done)); // R6
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready); // R8

endmodule

// File: tb/sim_ldst_unit.sv
// Directed bench for the load/store unit with a behavioural word memory.
module sim_ldst_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        done, wb_valid, misalign;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ldst_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
        .misalign(misalign)
    );

    // Behavioural memory: 16 words, programmable stall, read data one cycle after accept.
    logic [31:0] mem [16];
    int          stall_cfg = 0;
    int          wcnt;
    int          hs_cnt;
    logic [31:0] hs_addr, hs_wdata;
    logic [3:0]  hs_be;
    logic        hs_we;

    assign mem_ready = mem_valid && (wcnt >= stall_cfg);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++)
                mem[i] <= {8'h80 + 8'(i), 8'h11 * 8'(i), 8'hF0 - 8'(i), 8'h70 ^ 8'(i)};
            wcnt <= 0; hs_cnt <= 0; mem_rvalid <= 1'b0; mem_rdata <= '0;
            hs_addr <= '0; hs_wdata <= '0; hs_be <= '0; hs_we <= 1'b0;
        end else begin
            mem_rvalid <= 1'b0;
            if (mem_valid && mem_ready) begin
                hs_cnt <= hs_cnt + 1; hs_addr <= mem_addr; hs_be <= mem_be;
                hs_we <= mem_we; hs_wdata <= mem_wdata; wcnt <= 0;
                if (mem_we) begin
                    for (int l = 0; l < 4; l++)
                        if (mem_be[l]) mem[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
                end else begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[mem_addr[5:2]];
                end
            end else if (mem_valid) begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [2:0] f3, input logic [1:0] off);
        case (f3[1:0])
            2'b00:   return 4'b0001 << off;
            2'b01:   return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [2:0] f3, input logic [1:0] off);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*off +: 8];
        h = off[1] ? w[31:16] : w[15:0];
        case (f3)
            3'b000:  return {{24{b[7]}}, b};
            3'b001:  return {{16{h[15]}}, h};
            3'b100:  return {24'd0, b};
            3'b101:  return {16'd0, h};
            default: return w;
        endcase
    endfunction

    // Offer one instruction; returns at the negedge after acceptance.
    task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr = ins; rs1_val = a; rs2_val = b; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Wait for done; report request cycles and the write-back seen with done.
    task automatic wait_done(output bit got, output int vcyc, output bit busy_ok,
                             output logic wv, output logic [4:0] wr, output logic [31:0] wd);
        got = 0; vcyc = 0; busy_ok = 1; wv = 0; wr = 0; wd = 0;
        for (int k = 0; k < 40; k++) begin
            if (done) begin
                got = 1; wv = wb_valid; wr = wb_rd; wd = wb_data;
                break;
            end
            if (mem_valid) vcyc++;
            if (req_ready) busy_ok = 0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R11 req_ready", 32'(req_ready), 1);
        chk(mem_valid == 1'b0, "R11 mem_valid", 32'(mem_valid), 0);
        chk(done == 1'b0, "R11 done", 32'(done), 0);
        chk(wb_valid == 1'b0, "R11 wb_valid", 32'(wb_valid), 0);
        chk(misalign == 1'b0, "R11 misalign", 32'(misalign), 0);
    endtask

    task automatic t_load(input logic [2:0] f3, input logic [4:0] rd, input logic [31:0] base,
                          input logic [11:0] imm, input int stall);
        logic [31:0] ea, w, exp;
        int h0, vc;
        bit got, bok;
        logic wv; logic [4:0] wr; logic [31:0] wd;
        ea = base + {{20{imm[11]}}, imm};
        w = mem[ea[5:2]];
        exp = exp_load(w, f3, ea[1:0]);
        h0 = hs_cnt; stall_cfg = stall;
        issue({imm, 5'd1, f3, rd, 7'b0000011}, base, 32'hDEAD_BEEF);
        wait_done(got, vc, bok, wv, wr, wd);
        chk(got, "R9 load done", 32'(got), 1);
        chk(hs_cnt == h0 + 1, "R6 one read", 32'(hs_cnt - h0), 1);
        chk(hs_addr == {ea[31:2], 2'b00}, "R1 load addr", hs_addr, {ea[31:2], 2'b00});
        chk(hs_we == 1'b0 && hs_be == exp_be(f3, ea[1:0]), "R5 load be/we", {27'd0, hs_we, hs_be}, {28'd0, exp_be(f3, ea[1:0])});
        chk(vc == stall + 1 && bok, "R8 load request held", 32'(vc), 32'(stall + 1));
        if (rd != 0) begin
            chk(wv == 1'b1 && wr == rd, "R9 wb with done", {26'd0, wv, wr}, {26'd1, rd});
            chk(wd == exp, "R2 R3 load data", wd, exp);
        end else begin
            chk(wv == 1'b0, "R6 no wb for x0", 32'(wv), 0);
        end
        @(negedge clk);
        chk(done == 1'b0 && wb_valid == 1'b0, "R9 done single cycle", {30'd0, done, wb_valid}, 0);
    endtask

    task automatic t_store(input logic [2:0] f3, input logic [31:0] base, input logic [11:0] imm,
                           input logic [31:0] src, input int stall);
        logic [31:0] ea, w, expw, sv;
        logic [3:0] be;
        int h0, vc;
        bit got, bok, lanes_ok;
        logic wv; logic [4:0] wr; logic [31:0] wd;
        ea = base + {{20{imm[11]}}, imm};
        be = exp_be(f3, ea[1:0]);
        sv = (f3 == 3'b000) ? {4{src[7:0]}} : (f3 == 3'b001) ? {2{src[15:0]}} : src;
        w = mem[ea[5:2]];
        expw = w;
        for (int l = 0; l < 4; l++) if (be[l]) expw[8*l +: 8] = sv[8*l +: 8];
        h0 = hs_cnt; stall_cfg = stall;
        issue({imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011}, base, src);
        wait_done(got, vc, bok, wv, wr, wd);
        chk(got && hs_cnt == h0 + 1, "R9 store done", 32'(hs_cnt - h0), 1);
        chk(hs_addr == {ea[31:2], 2'b00}, "R1 store addr", hs_addr, {ea[31:2], 2'b00});
        chk(hs_we == 1'b1 && hs_be == be, "R5 store be", {27'd0, hs_we, hs_be}, {27'd1, be});
        lanes_ok = 1;
        for (int l = 0; l < 4; l++) if (be[l] && hs_wdata[8*l +: 8] != sv[8*l +: 8]) lanes_ok = 0;
        chk(lanes_ok, "R4 store lanes", hs_wdata, sv);
        chk(mem[ea[5:2]] == expw, "R4 memory word", mem[ea[5:2]], expw);
        chk(vc == stall + 1 && bok, "R8 store request held", 32'(vc), 32'(stall + 1));
        chk(wv == 1'b0, "R9 store no wb", 32'(wv), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", 32'(done), 0);
    endtask

    task automatic t_misalign(input logic [31:0] ins, input logic [31:0] base, input string tag);
        int h0;
        bit any;
        h0 = hs_cnt; stall_cfg = 0;
        issue(ins, base, 32'h1234_5678);
        chk(misalign == 1'b1, {"R7 flag ", tag}, 32'(misalign), 1);
        any = 0;
        @(negedge clk);
        chk(misalign == 1'b0, {"R7 one cycle ", tag}, 32'(misalign), 0);
        for (int k = 0; k < 4; k++) begin
            if (done || mem_valid) any = 1;
            @(negedge clk);
        end
        chk(!any && hs_cnt == h0, {"R7 no request ", tag}, 32'(hs_cnt - h0), 0);
    endtask

    task automatic t_ignored(input logic [31:0] ins, input string tag);
        int h0;
        bit any;
        h0 = hs_cnt; any = 0;
        issue(ins, 32'h100, 32'h0);
        for (int k = 0; k < 5; k++) begin
            if (done || mem_valid || misalign || !req_ready || wb_valid) any = 1;
            @(negedge clk);
        end
        chk(!any && hs_cnt == h0, {"R10 ignored ", tag}, 32'(hs_cnt - h0), 0);
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        // loads: every funct3, several offsets, negative immediate, stalls
        for (int o = 0; o < 4; o++) t_load(3'b000, 5'd5, 32'h100, 12'(o), 0);
        for (int o = 0; o < 4; o++) t_load(3'b100, 5'd6, 32'h104, 12'(o), 1);
        t_load(3'b001, 5'd7, 32'h108, 12'd0, 0);
        t_load(3'b001, 5'd7, 32'h10C, 12'd2, 2);
        t_load(3'b101, 5'd8, 32'h110, 12'd0, 0);
        t_load(3'b101, 5'd8, 32'h110, 12'd2, 0);
        t_load(3'b010, 5'd9, 32'h120, 12'hFF8, 3);
        t_load(3'b000, 5'd0, 32'h100, 12'd3, 0);
        // stores: sizes, offsets, split immediate incl. negative
        t_store(3'b000, 32'h100, 12'd1, 32'hAABB_CC5A, 0);
        t_store(3'b000, 32'h100, 12'd3, 32'h0000_00E1, 2);
        t_store(3'b001, 32'h104, 12'd2, 32'h9999_8421, 0);
        t_store(3'b001, 32'h104, 12'd0, 32'h0000_7F3C, 1);
        t_store(3'b010, 32'h140, 12'hFE0, 32'hCAFE_F00D, 3);
        t_store(3'b010, 32'h0F0, 12'h03C, 32'h1357_9BDF, 0);
        // read back a stored byte through a signed load
        t_load(3'b000, 5'd3, 32'h100, 12'd3, 0);
        // misaligned accesses
        t_misalign({12'd1, 5'd1, 3'b001, 5'd4, 7'b0000011}, 32'h100, "lh odd");
        t_misalign({12'd2, 5'd1, 3'b010, 5'd4, 7'b0000011}, 32'h100, "lw +2");
        t_misalign({7'd0, 5'd2, 5'd1, 3'b010, 5'd3, 7'b0100011}, 32'h100, "sw +3");
        t_misalign({7'd0, 5'd2, 5'd1, 3'b001, 5'd1, 7'b0100011}, 32'h100, "sh +1");
        // unsupported instructions
        t_ignored({12'd4, 5'd1, 3'b000, 5'd2, 7'b0010011}, "alu op");
        t_ignored({12'd0, 5'd1, 3'b011, 5'd2, 7'b0000011}, "load f3 011");
        t_ignored({7'd0, 5'd2, 5'd1, 3'b100, 5'd0, 7'b0100011}, "store f3 100");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule